// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This block is the decode-stage interlock of a five-stage in-order pipeline. Each cycle it looks at the instruction in decode and at the instruction in execute. If the execute-stage instruction is a load whose destination register is a source that the decoded instruction really reads, it raises a stall. A stall holds the program counter and the fetch/decode register, and it makes the pipeline zero every control signal written into the decode/execute register. The consumer therefore waits in decode while a no-op travels down the pipeline behind the load.

A build parameter selects one of two variants. In the bypass variant the datapath forwards the loaded value from memory to execute, so one stall cycle is enough. In the no-bypass variant the consumer must wait until the load has completed write-back. The unit then also keeps a one-entry record of the load that has moved on to the memory stage, and the same dependency costs two stall cycles. Register zero is never a dependency. A source field whose read flag is low is never compared. The stall decision is made again every cycle, so a held instruction is released as soon as no matching load is left in the watched stages.

Top module: `load_use_stall`

## Requirements
- R1: While reset is low the memory-stage load record stays empty, whatever the execute inputs are. The first cycle after reset therefore cannot stall because of a load seen during reset.
- R2: When `ex_load` is 1, source 0 (bits [REG_W-1:0] of `id_src_idx`) is read (`id_src_rd[0]`=1) and it equals `ex_dst`, the unit stalls in that same cycle.
- R3: When `ex_load` is 1, source 1 (bits [2*REG_W-1:REG_W]) is read (`id_src_rd[1]`=1) and it equals `ex_dst`, the unit stalls in that same cycle.
- R4: A stall cycle drives `pc_we`=0, `ifid_we`=0 and `idex_bubble`=1. Every other cycle drives `pc_we`=1, `ifid_we`=1 and `idex_bubble`=0.
- R5: A source whose register number is 0 never causes a stall, even when it matches the load destination.
- R6: A source whose read flag is 0 never causes a stall, even when its number matches.
- R7: An execute-stage instruction with `ex_load`=0 never causes a stall, even when its destination matches a read source.
- R8: In the bypass variant, once the execute stage holds a bubble, the held consumer is released on the next cycle, so a load followed by its consumer costs exactly one stall cycle.
- R9: In the no-bypass variant, a load that was in execute in the previous cycle (now in memory) still stalls a matching read source. A load followed by its consumer costs exactly two stall cycles.
- R10: A load whose destination differs from every read source does not stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the memory-stage load record |
| id_src_idx | input | NUM_SRC*REG_W | Source register numbers of the decoded instruction, source i at bits [i*REG_W +: REG_W] |
| id_src_rd | input | NUM_SRC | Bit i high when the decoded instruction reads source i |
| ex_load | input | 1 | Execute-stage instruction is a load |
| ex_dst | input | REG_W | Destination register of the execute-stage instruction |
| pc_we | output | 1 | Program counter write enable, low during a stall |
| ifid_we | output | 1 | Fetch/decode register write enable, low during a stall |
| idex_bubble | output | 1 | High to zero the control signals entering the decode/execute register |

## Verification
Two matches can be present in the same cycle.

In the first case both source fields match the execute-stage load. The bench provokes this by giving both sources the load's destination. It judges the result by requiring exactly one stall pattern, never a partial one.

In the second case, in the no-bypass variant, a new load in execute matches one source while the older load in memory matches the other. The bench provokes this by following one load immediately with a second load to a different register, while decode reads both registers. It then checks the next cycle, in which only the memory-stage match remains. The stall must persist there in the no-bypass variant and must be absent in the bypass variant.

// File: rtl/load_use_pkg.sv
package load_use_pkg;

   // Selects whether the datapath forwards load data from the memory stage.
   typedef enum logic {
      LU_NO_BYPASS = 1'b0,
      LU_BYPASS    = 1'b1
   } lu_mode_e;

endpackage

// File: rtl/lu_src_cmp.sv
module lu_src_cmp #(
   parameter int REG_W      = 5,
   parameter bit ZERO_CONST = 1'b1
) (
   input  logic [REG_W-1:0] src,
   input  logic             src_rd,
   input  logic             prod_vld,
   input  logic [REG_W-1:0] prod_dst,
   output logic             hit
);

   logic same_reg;
   logic src_is_zero;

   assign same_reg    = (src == prod_dst);
   assign src_is_zero = ZERO_CONST && (src == '0);
   assign hit         = prod_vld && src_rd && same_reg && !src_is_zero;

   always_comb begin
      if (src_rd === 1'b0) begin
         a_r6_unread_ignored: assert (hit !== 1'b1);
      end
      if (ZERO_CONST && (src === '0)) begin
         a_r5_zero_ignored: assert (hit !== 1'b1);
      end
   end

endmodule

// File: rtl/lu_mem_shadow.sv
module lu_mem_shadow #(
   parameter int REG_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ex_load,
   input  logic [REG_W-1:0] ex_dst,
   output logic             mem_vld,
   output logic [REG_W-1:0] mem_dst
);

   // The execute stage always advances, so the next memory stage is the current execute.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_vld <= 1'b0;
         mem_dst <= '0;
      end else begin
         mem_vld <= ex_load;
         mem_dst <= ex_dst;
      end
   end

   a_r1_shadow_cleared: assert property (@(posedge clk) !rst_n |=> !mem_vld);

endmodule

// File: rtl/lu_stall_ctrl.sv
module lu_stall_ctrl #(
   parameter int NUM_SRC = 2
) (
   input  logic [NUM_SRC-1:0] ex_hits,
   input  logic [NUM_SRC-1:0] mem_hits,
   output logic               pc_we,
   output logic               ifid_we,
   output logic               idex_bubble
);

   logic stall;

   assign stall       = (|ex_hits) || (|mem_hits);
   assign pc_we       = !stall;
   assign ifid_we     = !stall;
   assign idex_bubble = stall;

endmodule

// File: rtl/load_use_stall.sv
module load_use_stall
   import load_use_pkg::*;
#(
   parameter int       REG_W      = 5,
   parameter int       NUM_SRC    = 2,
   parameter lu_mode_e MODE       = LU_BYPASS,
   parameter bit       ZERO_CONST = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_SRC*REG_W-1:0] id_src_idx,
   input  logic [NUM_SRC-1:0]       id_src_rd,
   input  logic                     ex_load,
   input  logic [REG_W-1:0]         ex_dst,
   output logic                     pc_we,
   output logic                     ifid_we,
   output logic                     idex_bubble
);

   localparam int SRC_BUS_W = NUM_SRC * REG_W;
   localparam bit WATCH_MEM = (MODE == LU_NO_BYPASS);

   if (REG_W < 1 || REG_W > 8) begin : g_bad_reg_w
      $error("load_use_stall: REG_W must lie in 1..8");
   end
   if (NUM_SRC < 1 || NUM_SRC > 4) begin : g_bad_num_src
      $error("load_use_stall: NUM_SRC must lie in 1..4");
   end
   if (SRC_BUS_W != $bits(id_src_idx)) begin : g_bad_bus
      $error("load_use_stall: source bus width mismatch");
   end

   logic             shadow_vld;
   logic [REG_W-1:0] shadow_dst;
   logic             mem_prod_vld;
   logic [NUM_SRC-1:0] ex_hits;
   logic [NUM_SRC-1:0] mem_hits;

   lu_mem_shadow #(.REG_W(REG_W)) u_shadow (
      .clk     (clk),
      .rst_n   (rst_n),
      .ex_load (ex_load),
      .ex_dst  (ex_dst),
      .mem_vld (shadow_vld),
      .mem_dst (shadow_dst)
   );

   // The memory-stage load is a producer only when no bypass path exists.
   assign mem_prod_vld = shadow_vld && WATCH_MEM;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      lu_src_cmp #(.REG_W(REG_W), .ZERO_CONST(ZERO_CONST)) u_ex_cmp (
         .src      (id_src_idx[i*REG_W +: REG_W]),
         .src_rd   (id_src_rd[i]),
         .prod_vld (ex_load),
         .prod_dst (ex_dst),
         .hit      (ex_hits[i])
      );
      lu_src_cmp #(.REG_W(REG_W), .ZERO_CONST(ZERO_CONST)) u_mem_cmp (
         .src      (id_src_idx[i*REG_W +: REG_W]),
         .src_rd   (id_src_rd[i]),
         .prod_vld (mem_prod_vld),
         .prod_dst (shadow_dst),
         .hit      (mem_hits[i])
      );
   end

   lu_stall_ctrl #(.NUM_SRC(NUM_SRC)) u_ctrl (
      .ex_hits     (ex_hits),
      .mem_hits    (mem_hits),
      .pc_we       (pc_we),
      .ifid_we     (ifid_we),
      .idex_bubble (idex_bubble)
   );

   // Set one cycle after reset so that $past never reaches into reset.
   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   if (MODE == LU_BYPASS) begin : g_chk_bypass
      // R8: a bubble in execute releases the held consumer
      a_r8_bypass_release: assert property (@(posedge clk) disable iff (!rst_n)
         (past_ok && $past(idex_bubble) && !ex_load) |-> (pc_we && ifid_we));
   end else begin : g_chk_nobypass
      // R9: the load that left execute still holds the unchanged consumer
      a_r9_second_stall: assert property (@(posedge clk) disable iff (!rst_n)
         (past_ok && $past(idex_bubble && ex_load && (|ex_hits))
          && $stable(id_src_idx) && $stable(id_src_rd)) |-> idex_bubble);
   end

endmodule

// File: tb/test_load_use_stall.sv
`timescale 1ns/1ps
module test_load_use_stall;
   import load_use_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] src = '0;
   logic [1:0] src_rd = '0;
   logic       ex_ld = 1'b0;
   logic [4:0] ex_d = '0;

   logic f_pc, f_if, f_bb, n_pc, n_if, n_bb;

   always #2 clk = ~clk;

   load_use_stall #(.REG_W(5), .NUM_SRC(2), .MODE(LU_BYPASS)) i_load_use_stall (
      .clk(clk), .rst_n(rst_n), .id_src_idx(src), .id_src_rd(src_rd),
      .ex_load(ex_ld), .ex_dst(ex_d),
      .pc_we(f_pc), .ifid_we(f_if), .idex_bubble(f_bb));

   load_use_stall #(.REG_W(5), .NUM_SRC(2), .MODE(LU_NO_BYPASS)) i_load_use_stall_nb (
      .clk(clk), .rst_n(rst_n), .id_src_idx(src), .id_src_rd(src_rd),
      .ex_load(ex_ld), .ex_dst(ex_d),
      .pc_we(n_pc), .ifid_we(n_if), .idex_bubble(n_bb));

   typedef struct {
      string      tag;
      logic [2:0] exp_f;
      logic [2:0] exp_n;
   } item_t;

   item_t q[$];
   int    nvec = 0;
   int    nbad = 0;
   bit    done = 1'b0;
   bit    prev_ld = 1'b0;
   logic [4:0] prev_d = '0;

   function automatic bit ref_hit(logic [9:0] s, logic [1:0] rd, bit ld, logic [4:0] d);
      bit h = 1'b0;
      for (int i = 0; i < 2; i++)
         if (ld && rd[i] && (s[i*5 +: 5] == d) && (d != 5'd0)) h = 1'b1;
      return h;
   endfunction

   // {pc_we, ifid_we, idex_bubble}
   function automatic logic [2:0] pat(bit stall);
      return stall ? 3'b001 : 3'b110;
   endfunction

   task automatic vec(string tag, logic [4:0] s0, logic [4:0] s1, logic [1:0] rd,
                      bit ld, logic [4:0] d, bit release_rst);
      item_t it;
      bit sf, sn;
      @(negedge clk);
      if (release_rst) begin
         rst_n = 1'b1;
         prev_ld = 1'b0;
      end
      src = {s1, s0}; src_rd = rd; ex_ld = ld; ex_d = d;
      sf = ref_hit({s1, s0}, rd, ld, d);
      sn = sf || ref_hit({s1, s0}, rd, prev_ld, prev_d);
      it.tag = tag; it.exp_f = pat(sf); it.exp_n = pat(sn);
      q.push_back(it);
      prev_ld = ld; prev_d = d;
      nvec++;
   endtask

   always @(negedge clk) begin
      #1;
      while (q.size() > 0) begin
         item_t it;
         it = q.pop_front();
         if ({f_pc, f_if, f_bb} !== it.exp_f) begin
            nbad++;
            $display("FAIL %s bypass variant: {pc_we,ifid_we,bubble} actual %b expected %b",
                     it.tag, {f_pc, f_if, f_bb}, it.exp_f);
         end
         if ({n_pc, n_if, n_bb} !== it.exp_n) begin
            nbad++;
            $display("FAIL %s no-bypass variant: {pc_we,ifid_we,bubble} actual %b expected %b",
                     it.tag, {n_pc, n_if, n_bb}, it.exp_n);
         end
      end
   end

   initial begin
      // Reset with a matching load sitting in execute: R1
      src = {5'd0, 5'd5}; src_rd = 2'b01; ex_ld = 1'b1; ex_d = 5'd5;
      repeat (3) @(negedge clk);
      vec("R1 reset leaves memory record empty", 5'd5, 5'd0, 2'b01, 1'b0, 5'd0, 1'b1);
      vec("R2 load then use on source 0",        5'd5, 5'd0, 2'b01, 1'b1, 5'd5, 1'b0);
      vec("R8 R9 R4 bubble in execute",          5'd5, 5'd0, 2'b01, 1'b0, 5'd0, 1'b0);
      vec("R8 R9 consumer released",             5'd5, 5'd0, 2'b01, 1'b0, 5'd0, 1'b0);
      vec("R10 load to unrelated register",      5'd5, 5'd7, 2'b11, 1'b1, 5'd6, 1'b0);
      vec("R9 memory-stage match only",          5'd6, 5'd0, 2'b01, 1'b0, 5'd0, 1'b0);
      vec("R3 load then use on source 1",        5'd2, 5'd9, 2'b11, 1'b1, 5'd9, 1'b0);
      vec("R6 unread source 1 ignored",          5'd2, 5'd9, 2'b01, 1'b1, 5'd9, 1'b0);
      vec("R5 register zero ignored",            5'd0, 5'd0, 2'b11, 1'b1, 5'd0, 1'b0);
      vec("R7 non-load producer ignored",        5'd4, 5'd0, 2'b01, 1'b0, 5'd4, 1'b0);
      vec("R2 R3 both sources match",            5'd3, 5'd3, 2'b11, 1'b1, 5'd3, 1'b0);
      vec("R9 execute and memory matches",       5'd3, 5'd8, 2'b11, 1'b1, 5'd8, 1'b0);
      vec("R9 R8 memory match after new load",   5'd8, 5'd1, 2'b11, 1'b1, 5'd11, 1'b0);
      vec("R6 unread source 0 ignored",          5'd12, 5'd1, 2'b10, 1'b1, 5'd12, 1'b0);
      vec("R9 memory match on source 1",         5'd0, 5'd12, 2'b10, 1'b0, 5'd0, 1'b0);
      vec("R4 idle cycle",                       5'd1, 5'd2, 2'b11, 1'b0, 5'd0, 1'b0);
      @(negedge clk);
      @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

   initial begin
      #20000;
      if (!done) begin
         done = 1'b1;
         nbad++;
         $display("FAIL watchdog: run hung, actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

endmodule